// File: doc/BRIEF.md
# Address-Locking Shared Memory Arbiter

This block places several requesters, which may be separate processors or the time-sliced threads of one processor, onto a single synchronous memory port. In each cycle it grants at most one request, rotating priority so that every requester is served in turn. The memory port is driven combinationally from the granted request. Read data returns in the next cycle, flagged for the requester that asked.

A requester can make a read-modify-write indivisible. It raises the lock qualifier on a read, which opens a sequence, and later writes the same address, which closes it. While the sequence is open, the arbiter holds the locked address for that requester and withholds grants from every other requester that targets that address. Requests to any other address are still granted, so unrelated traffic keeps flowing. Grants to other requesters may fall between the two halves of the sequence without affecting it. A requester that has a sequence open and issues a second locked read receives an error pulse.

Top module: `atomic_mem_arbiter`

## Requirements
- R1: After reset, no requester holds a lock, no grant is given without a request, and no response or error flag is raised.
- R2: At most one grant is given per cycle, only to a requester whose valid is high. The memory port carries that requester's write flag, address and write data in the same cycle, and its enable is high exactly when a grant is given.
- R3: Priority rotates. After requester k is granted, the search for the next grant starts at requester k+1 (wrapping to 0), so when all four request together they are served in the order k+1, k+2, and so on.
- R4: A granted read (write flag 0) raises rsp_valid for that requester in the next cycle, with rsp_data equal to the memory content at the granted address.
- R5: A granted read with the lock qualifier set (write 0, lock 1) opens a sequence for that requester and records its address.
- R6: While a sequence is open, no other requester is granted an access of any kind to the recorded address.
- R7: While a sequence is open, other requesters accessing other addresses are granted normally.
- R8: A granted write by the owner to its recorded address closes the sequence. In the following cycle, a requester stalled on that address becomes eligible and, if no other requester competes, is granted.
- R9: A locked read granted to a requester whose sequence is already open raises lock_err for that requester for one cycle. It is performed as a plain read, and the recorded address is kept.
- R10: Concurrent locked increments of one counter by all requesters leave the counter exactly at its start value plus the number of increments.
- R11: A write by the owner to an address other than its recorded one does not close the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_write | input | NREQ | 1 = write, 0 = read |
| req_lock | input | NREQ | Lock qualifier, meaningful on reads |
| req_addr | input | NREQ*AW | Addresses, requester i at bits [i*AW +: AW] |
| req_wdata | input | NREQ*DW | Write data, requester i at bits [i*DW +: DW] |
| req_grant | output | NREQ | One-hot grant, same cycle as the request |
| rsp_valid | output | NREQ | Read data valid for that requester |
| rsp_data | output | DW | Read data, shared by all requesters |
| lock_err | output | NREQ | Pulse: locked read while a sequence is already open |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The bench first drives lone reads and simultaneous plain reads from all four requesters. These separate correct routing and data return from rotation order. It then sweeps every owner and competitor pair over one locked address, which shows that each competitor stalls and is released exactly when its owner closes. Directed cases with a neighbour address, a write by the owner to a foreign address, and a repeated locked read tell selective blocking apart from whole-bus blocking, a premature close, and a lost recorded address. Finally, all requesters hammer one counter and then two counters split by pairs, and the totals are compared with arithmetic sums. A lost update would show up as a short total.

// File: rtl/amr_pkg.sv
package amr_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_LREAD = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e acc_kind(input logic wr, input logic lk);
        if (wr)      return ACC_WRITE;
        else if (lk) return ACC_LREAD;
        else         return ACC_READ;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/amr_lock_table.sv
module amr_lock_table
    import amr_pkg::*;
#(
    parameter int unsigned NREQ = 4,
    parameter int unsigned AW   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          gnt_valid,
    input  logic [idx_width(NREQ)-1:0]    gnt_idx,
    input  acc_kind_e                     gnt_kind,
    input  logic [AW-1:0]                 gnt_addr,
    output logic [NREQ-1:0]               lock_open,
    output logic [NREQ*AW-1:0]            lock_addr_flat,
    output logic [NREQ-1:0]               lock_err
);
    localparam int unsigned IDXW = idx_width(NREQ);

    logic [AW-1:0] held_addr [NREQ];

    for (genvar i = 0; i < NREQ; i++) begin : g_entry
        logic mine;
        assign mine = gnt_valid && (gnt_idx == IDXW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                lock_open[i] <= 1'b0;
                held_addr[i] <= '0;
                lock_err[i]  <= 1'b0;
            end else begin
                lock_err[i] <= 1'b0;
                if (mine) begin
                    case (gnt_kind)
                        ACC_LREAD: begin
                            if (lock_open[i]) begin
                                lock_err[i] <= 1'b1;
                            end else begin
                                lock_open[i] <= 1'b1;
                                held_addr[i] <= gnt_addr;
                            end
                        end
                        ACC_WRITE: begin
                            if (lock_open[i] && (gnt_addr == held_addr[i]))
                                lock_open[i] <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end

        assign lock_addr_flat[i*AW +: AW] = held_addr[i];

        assert_lock_opens_R5: assert property (@(posedge clk) disable iff (rst)
            (mine && gnt_kind == ACC_LREAD && !lock_open[i])
            |=> (lock_open[i] && held_addr[i] == $past(gnt_addr)))
            else $error("lock did not open");

        assert_relock_flag_R9: assert property (@(posedge clk) disable iff (rst)
            (mine && gnt_kind == ACC_LREAD && lock_open[i])
            |=> (lock_err[i] && lock_open[i] && $stable(held_addr[i])))
            else $error("second locked read mishandled");

        assert_close_on_match_R8: assert property (@(posedge clk) disable iff (rst)
            (mine && gnt_kind == ACC_WRITE && lock_open[i] && gnt_addr == held_addr[i])
            |=> !lock_open[i])
            else $error("closing write left lock open");

        assert_foreign_write_keeps_R11: assert property (@(posedge clk) disable iff (rst)
            (mine && gnt_kind == ACC_WRITE && lock_open[i] && gnt_addr != held_addr[i])
            |=> (lock_open[i] && $stable(held_addr[i])))
            else $error("foreign write disturbed lock");
    end

endmodule

// File: rtl/amr_conflict.sv
module amr_conflict #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned AW   = 8
) (
    input  logic [NREQ*AW-1:0] req_addr,
    input  logic [NREQ-1:0]    lock_open,
    input  logic [NREQ*AW-1:0] lock_addr_flat,
    output logic [NREQ-1:0]    blocked
);
    for (genvar i = 0; i < NREQ; i++) begin : g_req
        logic [NREQ-1:0] hit;
        for (genvar j = 0; j < NREQ; j++) begin : g_owner
            if (i == j) begin : g_self
                assign hit[j] = 1'b0;
            end else begin : g_other
                assign hit[j] = lock_open[j] &&
                    (req_addr[i*AW +: AW] == lock_addr_flat[j*AW +: AW]);
            end
        end
        assign blocked[i] = |hit;
    end
endmodule

// File: rtl/amr_rr_pick.sv
module amr_rr_pick
    import amr_pkg::*;
#(
    parameter int unsigned NREQ = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NREQ-1:0]            eligible,
    output logic                       gnt_valid,
    output logic [idx_width(NREQ)-1:0] gnt_idx,
    output logic [NREQ-1:0]            gnt_onehot
);
    localparam int unsigned IDXW = idx_width(NREQ);

    logic [IDXW-1:0] ptr;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            int c;
            c = (int'(ptr) + k) % NREQ;
            if (eligible[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDXW'(c);
            end
        end
    end

    always_comb begin
        gnt_onehot = '0;
        if (gnt_valid) gnt_onehot[gnt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (gnt_valid) begin
            if (int'(gnt_idx) == NREQ - 1) ptr <= '0;
            else                           ptr <= gnt_idx + 1'b1;
        end
    end

    assert_grant_is_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> eligible[gnt_idx])
        else $error("grant to ineligible requester");

    assert_no_idle_when_asked_R2: assert property (@(posedge clk) disable iff (rst)
        (|eligible) |-> gnt_valid)
        else $error("eligible request left idle");

endmodule

// File: rtl/atomic_mem_arbiter.sv
module atomic_mem_arbiter
    import amr_pkg::*;
#(
    parameter int unsigned NREQ = 4,
    parameter int unsigned AW   = 8,
    parameter int unsigned DW   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      req_valid,
    input  logic [NREQ-1:0]      req_write,
    input  logic [NREQ-1:0]      req_lock,
    input  logic [NREQ*AW-1:0]   req_addr,
    input  logic [NREQ*DW-1:0]   req_wdata,
    output logic [NREQ-1:0]      req_grant,
    output logic [NREQ-1:0]      rsp_valid,
    output logic [DW-1:0]        rsp_data,
    output logic [NREQ-1:0]      lock_err,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata
);
    localparam int unsigned IDXW = idx_width(NREQ);

    logic [NREQ-1:0]    blocked;
    logic [NREQ-1:0]    eligible;
    logic [NREQ-1:0]    lock_open;
    logic [NREQ*AW-1:0] lock_addr_flat;
    logic               gnt_valid;
    logic [IDXW-1:0]    gnt_idx;
    logic [NREQ-1:0]    gnt_onehot;
    acc_kind_e          gnt_kind;
    logic [AW-1:0]      gnt_addr;

    amr_conflict #(.NREQ(NREQ), .AW(AW)) u_conflict (
        .req_addr       (req_addr),
        .lock_open      (lock_open),
        .lock_addr_flat (lock_addr_flat),
        .blocked        (blocked)
    );

    assign eligible = req_valid & ~blocked;

    amr_rr_pick #(.NREQ(NREQ)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .eligible   (eligible),
        .gnt_valid  (gnt_valid),
        .gnt_idx    (gnt_idx),
        .gnt_onehot (gnt_onehot)
    );

    assign gnt_addr = req_addr[gnt_idx*AW +: AW];
    assign gnt_kind = acc_kind(req_write[gnt_idx], req_lock[gnt_idx]);

    amr_lock_table #(.NREQ(NREQ), .AW(AW)) u_locks (
        .clk            (clk),
        .rst            (rst),
        .gnt_valid      (gnt_valid),
        .gnt_idx        (gnt_idx),
        .gnt_kind       (gnt_kind),
        .gnt_addr       (gnt_addr),
        .lock_open      (lock_open),
        .lock_addr_flat (lock_addr_flat),
        .lock_err       (lock_err)
    );

    assign req_grant = gnt_onehot;
    assign mem_en    = gnt_valid;
    assign mem_we    = gnt_valid && req_write[gnt_idx];
    assign mem_addr  = gnt_addr;
    assign mem_wdata = req_wdata[gnt_idx*DW +: DW];
    assign rsp_data  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= '0;
        else     rsp_valid <= gnt_onehot & ~req_write;
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant))
        else $error("more than one grant");

    assert_port_follows_grant_R2: assert property (@(posedge clk) disable iff (rst)
        mem_en == (|req_grant))
        else $error("memory enable out of step with grant");

    for (genvar i = 0; i < NREQ; i++) begin : g_chk
        assert_grant_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
            req_grant[i] |-> req_valid[i])
            else $error("grant without request");

        assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[i] |-> $past(req_grant[i] && !req_write[i]))
            else $error("response without read grant");

        for (genvar j = 0; j < NREQ; j++) begin : g_pair
            if (i != j) begin : g_diff
                assert_locked_addr_shielded_R6: assert property (@(posedge clk) disable iff (rst)
                    (req_grant[i] && lock_open[j])
                    |-> (req_addr[i*AW +: AW] != lock_addr_flat[j*AW +: AW]))
                    else $error("access to address locked by another requester");
            end
        end
    end

endmodule

// File: tb/sim_atomic_mem_arbiter.sv
module sim_atomic_mem_arbiter;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int K  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          v_u  [N];
    logic          wr_u [N];
    logic          lk_u [N];
    logic [AW-1:0] ad_u [N];
    logic [DW-1:0] wd_u [N];

    logic [N-1:0]    req_valid, req_write, req_lock;
    logic [N*AW-1:0] req_addr;
    logic [N*DW-1:0] req_wdata;
    logic [N-1:0]    req_grant, rsp_valid, lock_err;
    logic [DW-1:0]   rsp_data;
    logic            mem_en, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_valid[i]             = v_u[i];
            req_write[i]             = wr_u[i];
            req_lock[i]              = lk_u[i];
            req_addr[i*AW +: AW]     = ad_u[i];
            req_wdata[i*DW +: DW]    = wd_u[i];
        end
    end

    atomic_mem_arbiter #(.NREQ(N), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_lock(req_lock),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .lock_err(lock_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [DW-1:0] mem [1 << AW];
    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = DW'(a * 3 + 1);
        mem_rdata = '0;
    end
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 3 + 1);
    endfunction

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int i = 0; i < N; i++) begin
            v_u[i] = 1'b0; wr_u[i] = 1'b0; lk_u[i] = 1'b0;
            ad_u[i] = '0; wd_u[i] = '0;
        end
    endtask

    task automatic set_req(input int id, input logic w, input logic l,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        v_u[id] = 1'b1; wr_u[id] = w; lk_u[id] = l; ad_u[id] = a; wd_u[id] = d;
    endtask

    // Called at a negative edge; returns just after the rising edge that took the grant.
    task automatic wait_grant(input int id);
        forever begin
            #1;
            if (req_grant[id]) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic inc_thread(input int id, input logic [AW-1:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            set_req(id, 1'b0, 1'b1, a, '0);
            wait_grant(id);
            @(negedge clk);
            if (!rsp_valid[id]) begin
                checks++; failures++;
                $display("FAIL R10 missing read response id=%0d actual=0 expected=1", id);
            end
            set_req(id, 1'b1, 1'b0, a, rsp_data + 1'b1);
            wait_grant(id);
            @(negedge clk);
            v_u[id] = 1'b0;
        end
    endtask

    task automatic read_back(input logic [AW-1:0] a, output logic [DW-1:0] d);
        set_req(0, 1'b0, 1'b0, a, '0);
        wait_grant(0);
        @(negedge clk);
        v_u[0] = 1'b0;
        d = rsp_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        chk(req_grant == '0, "R1 grant idle", 32'(req_grant), 0);
        chk(rsp_valid == '0, "R1 no response", 32'(rsp_valid), 0);
        chk(lock_err == '0,  "R1 no error", 32'(lock_err), 0);
        @(negedge clk);

        // R2/R4: lone read by requester 2 from address 5
        set_req(2, 1'b0, 1'b0, 8'd5, '0);
        #1;
        chk(req_grant == 4'b0100, "R2 lone grant", 32'(req_grant), 32'h4);
        chk(mem_en && !mem_we && mem_addr == 8'd5, "R2 port routing", 32'(mem_addr), 5);
        next_cycle();
        v_u[2] = 1'b0;
        chk(rsp_valid == 4'b0100, "R4 rsp_valid", 32'(rsp_valid), 32'h4);
        chk(rsp_data == init_val(5), "R4 read data", 32'(rsp_data), 32'(init_val(5)));

        // R3: all request together; pointer now at 3
        for (int i = 0; i < N; i++) set_req(i, 1'b0, 1'b0, AW'(i + 1), '0);
        for (int k = 0; k < N; k++) begin
            int e;
            e = (3 + k) % N;
            #1;
            chk(req_grant == N'(1 << e), "R3 rotation", 32'(req_grant), 32'(1 << e));
            next_cycle();
            v_u[e] = 1'b0;
        end

        // R5: requester 0 locks address 10 (pointer at 3)
        set_req(0, 1'b0, 1'b1, 8'd10, '0);
        #1;
        chk(req_grant == 4'b0001, "R5 locked read grant", 32'(req_grant), 1);
        next_cycle();
        v_u[0] = 1'b0;
        chk(rsp_data == init_val(10), "R5 locked read data", 32'(rsp_data), 32'(init_val(10)));

        // R6/R7: requester 1 on locked address, requester 2 on neighbour
        set_req(1, 1'b0, 1'b0, 8'd10, '0);
        set_req(2, 1'b0, 1'b0, 8'd11, '0);
        #1;
        chk(req_grant == 4'b0100, "R7 neighbour proceeds", 32'(req_grant), 32'h4);
        next_cycle();
        v_u[2] = 1'b0;
        set_req(3, 1'b1, 1'b0, 8'd10, 16'hdead);
        #1;
        chk(req_grant == 4'b0000, "R6 competitors stalled", 32'(req_grant), 0);
        next_cycle();
        #1;
        chk(req_grant == 4'b0000, "R6 still stalled", 32'(req_grant), 0);
        @(negedge clk);
        v_u[3] = 1'b0;

        // R11: owner writes a foreign address
        set_req(0, 1'b1, 1'b0, 8'd20, 16'h0077);
        #1;
        chk(req_grant == 4'b0001, "R11 owner foreign write", 32'(req_grant), 1);
        next_cycle();
        v_u[0] = 1'b0;
        #1;
        chk(req_grant == 4'b0000, "R11 lock kept", 32'(req_grant), 0);
        @(negedge clk);

        // R9: second locked read by owner to address 30
        set_req(0, 1'b0, 1'b1, 8'd30, '0);
        #1;
        chk(req_grant == 4'b0001, "R9 relock grant", 32'(req_grant), 1);
        next_cycle();
        v_u[0] = 1'b0;
        chk(lock_err == 4'b0001, "R9 error pulse", 32'(lock_err), 1);
        chk(rsp_data == init_val(30), "R9 plain read data", 32'(rsp_data), 32'(init_val(30)));
        #1;
        chk(req_grant == 4'b0000, "R9 recorded address kept", 32'(req_grant), 0);
        @(negedge clk);
        chk(lock_err == 4'b0000, "R9 pulse ends", 32'(lock_err), 0);

        // R8: owner closes; stalled requester 1 granted the cycle after
        set_req(0, 1'b1, 1'b0, 8'd10, 16'h00ab);
        #1;
        chk(req_grant == 4'b0001, "R8 closing write", 32'(req_grant), 1);
        next_cycle();
        v_u[0] = 1'b0;
        #1;
        chk(req_grant == 4'b0010, "R8 waiter released", 32'(req_grant), 2);
        next_cycle();
        v_u[1] = 1'b0;
        chk(rsp_data == 16'h00ab, "R8 waiter sees write", 32'(rsp_data), 32'hab);

        // R6/R8 sweep over every owner and competitor
        for (int o = 0; o < N; o++) begin
            for (int x = 0; x < N; x++) begin
                if (x != o) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] d;
                    a = AW'(60 + o);
                    d = DW'(16'h100 + o * 16 + x);
                    set_req(o, 1'b0, 1'b1, a, '0);
                    wait_grant(o);
                    @(negedge clk);
                    v_u[o] = 1'b0;
                    set_req(x, 1'b0, 1'b0, a, '0);
                    #1;
                    chk(req_grant == '0, "R6 sweep stall", 32'(req_grant), 0);
                    @(negedge clk);
                    set_req(o, 1'b1, 1'b0, a, d);
                    #1;
                    chk(req_grant == N'(1 << o), "R8 sweep close", 32'(req_grant), 32'(1 << o));
                    next_cycle();
                    v_u[o] = 1'b0;
                    #1;
                    chk(req_grant == N'(1 << x), "R8 sweep release", 32'(req_grant), 32'(1 << x));
                    next_cycle();
                    v_u[x] = 1'b0;
                    chk(rsp_data == d, "R8 sweep data", 32'(rsp_data), 32'(d));
                end
            end
        end

        // R10: all four increment one counter
        fork
            inc_thread(0, 8'd50, K);
            inc_thread(1, 8'd50, K);
            inc_thread(2, 8'd50, K);
            inc_thread(3, 8'd50, K);
        join
        @(negedge clk);
        read_back(8'd50, rd);
        chk(rd == init_val(50) + DW'(N * K), "R10 single counter total", 32'(rd),
            32'(init_val(50) + DW'(N * K)));

        // R10/R7: pairs on two separate counters
        fork
            inc_thread(0, 8'd70, K);
            inc_thread(1, 8'd70, K);
            inc_thread(2, 8'd71, K);
            inc_thread(3, 8'd71, K);
        join
        @(negedge clk);
        read_back(8'd70, rd);
        chk(rd == init_val(70) + DW'(2 * K), "R10 counter A total", 32'(rd),
            32'(init_val(70) + DW'(2 * K)));
        @(negedge clk);
        read_back(8'd71, rd);
        chk(rd == init_val(71) + DW'(2 * K), "R10 counter B total", 32'(rd),
            32'(init_val(71) + DW'(2 * K)));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule